// File: doc/BRIEF.md
# Sparse-Space PCI Address Translator

This block sits between a processor's uncached physical address space and a PCI host controller. Each request carries a 40-bit CPU physical address, a write flag and 32 bits of write data. The block finds out which window of the controller address space the request falls into: sparse memory, dense memory, sparse I/O, configuration, or the controller's own registers. For a supported window it turns the request into one PCI transaction. That transaction has a 32-bit PCI address, active-low byte enables, a space code, the number of the target bus controller (hose), and write data masked to the enabled lanes.

In the sparse windows, the size and position of the access travel inside the CPU address. Bits 6:5 give the starting byte and bits 4:3 give the length. The in-window offset is shifted right by five. The PCI address bits that lie above the shifted offset come from a high-address extension register: one register for memory and one for I/O. Both registers sit behind a small register port for write and read-back.

Requests enter and leave through valid/ready handshakes, and the block holds one registered transaction. A request that cannot be turned into a legal transaction is still consumed. It raises a one-cycle error pulse instead of producing output.

Top module: `sxl_top`

## Requirements
- R1: After a cycle with `rst` high, `out_valid` and `err_flag` are 0, and both extension registers read back as 0.
- R2: With CPU address bits 39:35 equal to 11111, the space code comes from bits 32:29 as follows. Bit 32 = 0 gives sparse memory (code 0). Bits 32:31 = 10 give dense memory (code 2). Bits 32:30 = 110 give sparse I/O (code 1). Bits 32:29 = 1110 give configuration (code 3). Bits 32:29 = 1111 (the controller register window) is not a PCI target and is an error. Any other value of bits 39:35 is also an error.
- R3: `out_hose` equals CPU address bits 34:33 of the accepted request.
- R4: In sparse spaces, offset = address bits 6:5 and length = bits 4:3. Lengths 00, 01, 10 and 11 select byte, word, tribyte and longword. The active-low enables are as follows. Byte at offsets 0/1/2/3: 1110/1101/1011/0111. Word at offsets 0/1/2: 1100/1001/0011. Tribyte at offsets 0/1: 1000/0001. Longword only at offset 2: 0000.
- R5: A sparse request whose offset/length pair is missing from the R4 table, or whose address bits 2:0 are nonzero, is treated like the error cases of R2. It is accepted, `err_flag` is 1 for exactly the next cycle, and no transaction is produced.
- R6: For sparse memory, `out_addr` = {memory extension register bits 31:27, CPU address bits 31:7, 00}.
- R7: For sparse I/O, `out_addr` = {I/O extension register bits 31:25, CPU bits 29:7, 00}. For configuration, `out_addr` = {8'h00, CPU bits 28:7, 00}.
- R8: For dense memory, `out_addr` equals CPU address bits 31:0, and `out_be_n` is 0000.
- R9: `out_wdata` carries each request data byte whose enable is 0 and carries 00 in every disabled byte. `out_write` equals the request's write flag.
- R10: `req_ready` is 1 when the output stage is empty or `out_ready` is 1. An accepted request's result appears in the cycle after acceptance. A result waiting with `out_ready` low stays unchanged.
- R11: A register-port write at offset 0x400 loads the memory extension register, and a write at 0x440 loads the I/O extension register. `csr_rdata` returns the addressed register, and returns 0 at any other offset. A write at any other offset changes neither register.
- R12: A request accepted in the same cycle as an extension-register write is translated with the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 40 | CPU physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data in the lane set by the offset |
| out_valid | output | 1 | PCI transaction present |
| out_ready | input | 1 | Consumer takes the transaction |
| out_addr | output | 32 | PCI address |
| out_be_n | output | 4 | Active-low byte enables |
| out_space | output | 2 | 0 memory, 1 I/O, 2 dense memory, 3 configuration |
| out_hose | output | 2 | Target bus controller number |
| out_write | output | 1 | Write flag of the transaction |
| out_wdata | output | 32 | Lane-masked write data |
| err_flag | output | 1 | One-cycle pulse for a rejected request |
| csr_we | input | 1 | Register-port write strobe |
| csr_addr | input | 12 | Register-port byte offset |
| csr_wdata | input | 32 | Register-port write data |
| csr_rdata | output | 32 | Register-port read data |

## Verification
The two functions that can coincide are a register-port write to an extension register and the acceptance of a sparse request that needs that register. Random stimulus strobes the register port on about one cycle in six, with new data each time, while requests keep arriving. A directed step also puts a memory-register write and a sparse memory request in the same cycle. In every such cycle, the cycle-level reference model translates with the register value held before the edge. The upper PCI address bits of the resulting transaction are then judged against that older value and reported under R12.

// File: rtl/sxl_pkg.sv
`timescale 1ns/1ps
package sxl_pkg;

    localparam int CPU_AW     = 40;
    localparam int PCI_AW     = 32;
    localparam int DATA_W     = 32;
    localparam int LANES      = DATA_W / 8;
    localparam int MEM_OFS_W  = 27;
    localparam int IO_OFS_W   = 25;
    localparam int CFG_OFS_W  = 24;
    localparam int SHIFT      = 5;
    localparam int MEM_HI_W   = PCI_AW - MEM_OFS_W;
    localparam int IO_HI_W    = PCI_AW - IO_OFS_W;
    localparam int CFG_HI_W   = PCI_AW - CFG_OFS_W;

    typedef enum logic [1:0] {
        SP_MEM   = 2'd0,
        SP_IO    = 2'd1,
        SP_DENSE = 2'd2,
        SP_CFG   = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        RG_SMEM,
        RG_DENSE,
        RG_SIO,
        RG_CFG,
        RG_CTRL,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic [PCI_AW-1:0] addr;
        logic [LANES-1:0]  be_n;
        space_e            space;
        logic [1:0]        hose;
        logic              write;
        logic [DATA_W-1:0] data;
    } pci_txn_t;

    // Returns {legal, be_n} for a sparse offset/length pair.
    function automatic logic [LANES:0] be_lookup(input logic [1:0] off,
                                                 input logic [1:0] len);
        logic [LANES-1:0] be;
        logic             ok;
        be = '1;
        ok = 1'b0;
        unique case (len)
            2'd0: begin
                be = ~(4'b0001 << off);
                ok = 1'b1;
            end
            2'd1: begin
                case (off)
                    2'd0:    begin be = 4'b1100; ok = 1'b1; end
                    2'd1:    begin be = 4'b1001; ok = 1'b1; end
                    2'd2:    begin be = 4'b0011; ok = 1'b1; end
                    default: begin be = 4'b1111; ok = 1'b0; end
                endcase
            end
            2'd2: begin
                case (off)
                    2'd0:    begin be = 4'b1000; ok = 1'b1; end
                    2'd1:    begin be = 4'b0001; ok = 1'b1; end
                    default: begin be = 4'b1111; ok = 1'b0; end
                endcase
            end
            default: begin
                ok = (off == 2'd2);
                be = ok ? 4'b0000 : 4'b1111;
            end
        endcase
        return {ok, be};
    endfunction

endpackage

// File: rtl/sxl_region_dec.sv
`timescale 1ns/1ps
module sxl_region_dec
    import sxl_pkg::*;
(
    input  logic [CPU_AW-1:29] addr_hi,
    output region_e            region,
    output logic [1:0]         hose
);
    always_comb begin
        hose = addr_hi[34:33];
        if (addr_hi[39:35] != 5'b11111)
            region = RG_NONE;
        else if (!addr_hi[32])
            region = RG_SMEM;
        else if (!addr_hi[31])
            region = RG_DENSE;
        else if (!addr_hi[30])
            region = RG_SIO;
        else if (!addr_hi[29])
            region = RG_CFG;
        else
            region = RG_CTRL;
    end
endmodule

// File: rtl/sxl_lane.sv
`timescale 1ns/1ps
module sxl_lane
    import sxl_pkg::*;
(
    input  logic [6:0]        addr_lo,
    input  logic              dense,
    input  logic [DATA_W-1:0] wdata,
    output logic              legal,
    output logic [LANES-1:0]  be_n,
    output logic [DATA_W-1:0] lane_data
);
    logic [LANES:0] lut;

    always_comb begin
        lut = be_lookup(addr_lo[6:5], addr_lo[4:3]);
        if (dense) begin
            be_n  = '0;
            legal = 1'b1;
        end else begin
            be_n  = lut[LANES-1:0];
            legal = lut[LANES] && (addr_lo[2:0] == 3'b000);
        end
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_data[8*b +: 8] = be_n[b] ? 8'h00 : wdata[8*b +: 8];
    end
endmodule

// File: rtl/sxl_addr_form.sv
`timescale 1ns/1ps
module sxl_addr_form
    import sxl_pkg::*;
(
    input  region_e           region,
    input  logic [31:0]       addr,
    input  logic [MEM_HI_W-1:0] mem_hi,
    input  logic [IO_HI_W-1:0]  io_hi,
    output logic [PCI_AW-1:0] pci_addr,
    output space_e            space
);
    always_comb begin
        pci_addr = '0;
        space    = SP_MEM;
        unique case (region)
            RG_SMEM: begin
                space    = SP_MEM;
                pci_addr = {mem_hi, addr[MEM_OFS_W+SHIFT-1:SHIFT+2], 2'b00};
            end
            RG_SIO: begin
                space    = SP_IO;
                pci_addr = {io_hi, addr[IO_OFS_W+SHIFT-1:SHIFT+2], 2'b00};
            end
            RG_CFG: begin
                space    = SP_CFG;
                pci_addr = {{CFG_HI_W{1'b0}}, addr[CFG_OFS_W+SHIFT-1:SHIFT+2], 2'b00};
            end
            RG_DENSE: begin
                space    = SP_DENSE;
                pci_addr = addr;
            end
            default: begin
                space    = SP_MEM;
                pci_addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/sxl_hae_regs.sv
`timescale 1ns/1ps
module sxl_hae_regs
    import sxl_pkg::*;
#(
    parameter int          CSR_AW  = 12,
    parameter logic [11:0] MEM_OFF = 12'h400,
    parameter logic [11:0] IO_OFF  = 12'h440
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    output logic [DATA_W-1:0] hae_mem,
    output logic [DATA_W-1:0] hae_io
);
    localparam logic [CSR_AW-1:0] MEM_A = MEM_OFF[CSR_AW-1:0];
    localparam logic [CSR_AW-1:0] IO_A  = IO_OFF[CSR_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hae_mem <= '0;
            hae_io  <= '0;
        end else if (csr_we) begin
            if (csr_addr == MEM_A) hae_mem <= csr_wdata;
            if (csr_addr == IO_A)  hae_io  <= csr_wdata;
        end
    end

    always_comb begin
        if (csr_addr == MEM_A)     csr_rdata = hae_mem;
        else if (csr_addr == IO_A) csr_rdata = hae_io;
        else                       csr_rdata = '0;
    end
endmodule

// File: rtl/sxl_top.sv
`timescale 1ns/1ps
module sxl_top
    import sxl_pkg::*;
#(
    parameter int          CSR_AW  = 12,
    parameter logic [11:0] MEM_OFF = 12'h400,
    parameter logic [11:0] IO_OFF  = 12'h440
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [39:0]       req_addr,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_addr,
    output logic [3:0]        out_be_n,
    output logic [1:0]        out_space,
    output logic [1:0]        out_hose,
    output logic              out_write,
    output logic [31:0]       out_wdata,
    output logic              err_flag,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata
);
    region_e           region;
    logic [1:0]        hose;
    logic              legal;
    logic [LANES-1:0]  be_n;
    logic [DATA_W-1:0] lane_data;
    logic [PCI_AW-1:0] pci_addr;
    space_e            space;
    logic [DATA_W-1:0] hae_mem;
    logic [DATA_W-1:0] hae_io;
    logic              is_dense;
    logic              bad;
    logic              accept;
    pci_txn_t          txn_d;
    pci_txn_t          txn_q;

    sxl_region_dec u_dec (
        .addr_hi (req_addr[CPU_AW-1:29]),
        .region  (region),
        .hose    (hose)
    );

    assign is_dense = (region == RG_DENSE);

    sxl_lane u_lane (
        .addr_lo   (req_addr[6:0]),
        .dense     (is_dense),
        .wdata     (req_wdata),
        .legal     (legal),
        .be_n      (be_n),
        .lane_data (lane_data)
    );

    sxl_addr_form u_form (
        .region   (region),
        .addr     (req_addr[31:0]),
        .mem_hi   (hae_mem[DATA_W-1 -: MEM_HI_W]),
        .io_hi    (hae_io[DATA_W-1 -: IO_HI_W]),
        .pci_addr (pci_addr),
        .space    (space)
    );

    sxl_hae_regs #(
        .CSR_AW  (CSR_AW),
        .MEM_OFF (MEM_OFF),
        .IO_OFF  (IO_OFF)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr[CSR_AW-1:0]),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .hae_mem   (hae_mem),
        .hae_io    (hae_io)
    );

    always_comb begin
        bad = (region == RG_NONE) || (region == RG_CTRL) || !legal;
        txn_d.addr  = pci_addr;
        txn_d.be_n  = be_n;
        txn_d.space = space;
        txn_d.hose  = hose;
        txn_d.write = req_write;
        txn_d.data  = lane_data;
    end

    assign req_ready = !out_valid || out_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            err_flag  <= 1'b0;
            txn_q     <= '0;
        end else begin
            err_flag <= accept && bad;
            if (accept) begin
                out_valid <= !bad;
                if (!bad) txn_q <= txn_d;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign out_addr  = txn_q.addr;
    assign out_be_n  = txn_q.be_n;
    assign out_space = txn_q.space;
    assign out_hose  = txn_q.hose;
    assign out_write = txn_q.write;
    assign out_wdata = txn_q.data;
endmodule

// File: rtl/sxl_checker.sv
`timescale 1ns/1ps
module sxl_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_addr,
    input logic [3:0]  out_be_n,
    input logic [1:0]  out_space,
    input logic        err_flag,
    input logic        csr_we,
    input logic [31:0] hae_mem,
    input logic [31:0] hae_io
);
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !err_flag));

    p_sparse_be_r4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_space != 2'd2) |-> (out_be_n != 4'b1111));

    p_err_src_r5: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> $past(req_valid && req_ready));

    p_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !out_valid);

    p_align_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_space != 2'd2) |-> (out_addr[1:0] == 2'b00));

    p_dense_be_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_space == 2'd2) |-> (out_be_n == 4'b0000));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_addr) && $stable(out_be_n) && $stable(out_space)));

    p_new_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(req_valid && req_ready));

    p_hae_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> ($stable(hae_mem) && $stable(hae_io)));
endmodule

bind sxl_top sxl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_be_n  (out_be_n),
    .out_space (out_space),
    .err_flag  (err_flag),
    .csr_we    (csr_we),
    .hae_mem   (hae_mem),
    .hae_io    (hae_io)
);

// File: tb/sim_sxl_top.sv
`timescale 1ns/1ps
module sim_sxl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr;
    logic [3:0]  out_be_n;
    logic [1:0]  out_space;
    logic [1:0]  out_hose;
    logic        out_write;
    logic [31:0] out_wdata;
    logic        err_flag;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = 12'h400;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sxl_top u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_be_n(out_be_n), .out_space(out_space), .out_hose(out_hose),
        .out_write(out_write), .out_wdata(out_wdata), .err_flag(err_flag),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata)
    );

    // reference model state
    bit          m_ov, m_err, m_coinc;
    logic [31:0] m_hm, m_hi;
    logic [31:0] m_addr, m_data;
    logic [3:0]  m_be;
    logic [1:0]  m_sp, m_hs;
    logic        m_wr;

    task automatic translate(input logic [39:0] a_in, input logic [31:0] d,
                             input logic [31:0] hm, input logic [31:0] hi,
                             output bit err, output bit uses_hae,
                             output logic [31:0] pa, output logic [3:0] be,
                             output logic [1:0] sp, output logic [1:0] hs,
                             output logic [31:0] od);
        logic [39:0] a, base, ofs;
        logic [31:0] hae, mask;
        int off, len, cnt;
        bit sparse;
        hs = a_in[34:33];
        a = a_in & ~(40'h3 << 33);
        err = 0; sparse = 1; uses_hae = 0; hae = 0; mask = 0; base = 0; sp = 0;
        if (a >= 40'hF800000000 && a <= 40'hF8FFFFFFFF) begin
            sp = 0; base = 40'hF800000000; hae = hm; mask = (32'd1 << 27) - 1; uses_hae = 1;
        end else if (a >= 40'hF900000000 && a <= 40'hF97FFFFFFF) begin
            sp = 2; base = 40'hF900000000; sparse = 0;
        end else if (a >= 40'hF980000000 && a <= 40'hF9BFFFFFFF) begin
            sp = 1; base = 40'hF980000000; hae = hi; mask = (32'd1 << 25) - 1; uses_hae = 1;
        end else if (a >= 40'hF9C0000000 && a <= 40'hF9DFFFFFFF) begin
            sp = 3; base = 40'hF9C0000000; hae = 0; mask = (32'd1 << 24) - 1;
        end else begin
            err = 1;
        end
        be = 4'b0000;
        pa = 0;
        if (!err && sparse) begin
            off = int'(a[6:5]); len = int'(a[4:3]); cnt = len + 1;
            if (a[2:0] != 3'b000) err = 1;
            if (len == 3) begin
                if (off != 2) err = 1;
            end else if (off + cnt > 4) err = 1;
            be = 4'b1111;
            for (int i = 0; i < 4; i++)
                if (len == 3 || (i >= off && i < off + cnt)) be[i] = 1'b0;
            ofs = (a - base) >> 5;
            pa = ((hae & ~mask) | (ofs[31:0] & mask)) & ~32'd3;
        end else if (!err) begin
            ofs = a - base;
            pa = ofs[31:0];
        end
        od = d;
        for (int i = 0; i < 4; i++) if (be[i]) od[8*i +: 8] = 8'h00;
    endtask

    always @(posedge clk) begin
        bit acc, e, uh;
        logic [31:0] pa, od;
        logic [3:0] be;
        logic [1:0] sp, hs;
        if (rst) begin
            m_ov = 0; m_err = 0; m_hm = 0; m_hi = 0; m_coinc = 0;
        end else begin
            acc = req_valid && (!m_ov || out_ready);
            if (acc) begin
                translate(req_addr, req_wdata, m_hm, m_hi, e, uh, pa, be, sp, hs, od);
                m_err = e;
                m_ov  = !e;
                if (!e) begin
                    m_addr = pa; m_be = be; m_sp = sp; m_hs = hs;
                    m_wr = req_write; m_data = od;
                    m_coinc = uh && csr_we &&
                              ((sp == 0 && csr_addr == 12'h400) || (sp == 1 && csr_addr == 12'h440));
                end
            end else begin
                m_err = 0;
                if (out_ready) m_ov = 0;
            end
            if (csr_we && csr_addr == 12'h400) m_hm = csr_wdata;
            if (csr_we && csr_addr == 12'h440) m_hi = csr_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string atag;
        logic [31:0] exp_rd;
        chk(req_ready == (!m_ov || out_ready), "R10 req_ready", 32'(req_ready), 32'(!m_ov || out_ready));
        chk(out_valid == m_ov, "R10 out_valid", 32'(out_valid), 32'(m_ov));
        chk(err_flag == m_err, "R5 err_flag", 32'(err_flag), 32'(m_err));
        if (m_ov && out_valid) begin
            if (m_coinc)        atag = "R12 out_addr";
            else if (m_sp == 0) atag = "R6 out_addr";
            else if (m_sp == 2) atag = "R8 out_addr";
            else                atag = "R7 out_addr";
            chk(out_addr == m_addr, atag, out_addr, m_addr);
            chk(out_be_n == m_be, (m_sp == 2) ? "R8 out_be_n" : "R4 out_be_n", 32'(out_be_n), 32'(m_be));
            chk(out_space == m_sp, "R2 out_space", 32'(out_space), 32'(m_sp));
            chk(out_hose == m_hs, "R3 out_hose", 32'(out_hose), 32'(m_hs));
            chk(out_wdata == m_data, "R9 out_wdata", out_wdata, m_data);
            chk(out_write == m_wr, "R9 out_write", 32'(out_write), 32'(m_wr));
        end
        exp_rd = (csr_addr == 12'h400) ? m_hm : (csr_addr == 12'h440) ? m_hi : 32'h0;
        chk(csr_rdata == exp_rd, "R11 csr_rdata", csr_rdata, exp_rd);
    endtask

    function automatic logic [39:0] make_addr(input int rg, input logic [1:0] hs,
                                              input logic [6:0] lo);
        logic [39:0] a;
        logic [31:0] r;
        r = $urandom;
        case (rg)
            0: a = {5'b11111, hs, 1'b0, r};
            1: a = {5'b11111, hs, 2'b10, r[30:0]};
            2: a = {5'b11111, hs, 3'b110, r[29:0]};
            3: a = {5'b11111, hs, 4'b1110, r[28:0]};
            4: a = {5'b11111, hs, 4'b1111, r[28:0]};
            default: a = {5'b01111, hs, 1'b1, r};
        endcase
        if (rg != 1) a[6:0] = lo;
        return a;
    endfunction

    initial begin
        #(8 * 60000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] offs [4];
        offs[0] = 12'h400; offs[1] = 12'h440; offs[2] = 12'h404; offs[3] = 12'h000;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
        chk(err_flag == 1'b0, "R1 err_flag", 32'(err_flag), 0);
        csr_addr = 12'h400; #1;
        chk(csr_rdata == 32'h0, "R1 hae_mem", csr_rdata, 0);
        csr_addr = 12'h440; #1;
        chk(csr_rdata == 32'h0, "R1 hae_io", csr_rdata, 0);

        // R11: write to unused offset leaves registers alone
        csr_we = 1; csr_addr = 12'h404; csr_wdata = 32'hDEADBEEF;
        @(negedge clk); compare_all();
        csr_we = 0; csr_addr = 12'h400;
        @(negedge clk); compare_all();
        csr_addr = 12'h440; #1; compare_all();

        // R12: directed coincidence of memory register write and sparse memory request
        csr_we = 1; csr_addr = 12'h400; csr_wdata = 32'hA8000000;
        out_ready = 1; req_valid = 1; req_write = 1; req_wdata = 32'h11223344;
        req_addr = {5'b11111, 2'b01, 1'b0, 32'h12345600} | 40'h40; // byte at offset 2
        @(negedge clk); compare_all();
        csr_we = 0; req_valid = 1;
        req_addr = {5'b11111, 2'b10, 1'b0, 32'h12345600} | 40'h40;
        @(negedge clk); compare_all();
        req_valid = 0;
        @(negedge clk); compare_all();

        // mixed stimulus
        for (int cyc = 0; cyc < 6000; cyc++) begin
            int rg, sel;
            logic [6:0] lo;
            logic [31:0] rr;
            compare_all();
            rr = $urandom;
            sel = int'(rr[2:0]);
            rg = (sel < 6) ? sel : int'(rr[3]);
            lo = {rr[9:8], rr[11:10], (rr[14:12] == 3'b111) ? rr[17:15] : 3'b000};
            req_valid = (rr[19:18] != 2'b00);
            req_addr  = make_addr(rg, rr[21:20], lo);
            req_write = rr[22];
            req_wdata = $urandom;
            out_ready = (cyc % 800 < 400) ? 1'b1 : (rr[24:23] != 2'b00);
            csr_we    = (rr[27:25] < 3'd1) || (rr[27:25] == 3'd5 && rr[28]);
            csr_addr  = offs[rr[30:29]];
            csr_wdata = $urandom;
            @(negedge clk);
        end
        compare_all();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule